// File: doc/BRIEF.md
# Status Register Write-Protect Controller

This block holds the protection state of a four-sector serial flash and rules on every write request. It has a status register with a write-enable latch, a two-bit protect selector and a hardware-guard enable bit. From decoded command strobes it decides two things. It decides whether a status-register write may go ahead, given the write-protect pin and the guard bit. It also decides whether a program or erase aimed at an address lands in a protected sector.

A status write is first held pending while chip select stays low. It commits on the first clock that sees chip select high, unless the hardware lock engages first. From the commit onward it cannot be revoked. Every accepted status write, program or erase opens a busy window of `BUSY_CYCLES` clocks. The write-enable latch clears when that window ends.

Top module: `sr_guard`

## Requirements
- R1: After reset, `status_o` is 0, `busy` is 0 and all four result pulses are 0.
- R2: `status_o` bit layout is {guard_en[7], 3'b000, prot_sel[3:2], wr_latch[1], busy[0]}. When the block is idle, `cmd_set_latch` sets bit 1 and `cmd_clr_latch` clears it. If several strobes coincide, the priority is sr_write, then prog/erase, then set_latch, then clr_latch.
- R3: An `cmd_sr_write` issued while the write latch is 0 is refused. `sr_reject` pulses in the next cycle and bits 7:2 stay unchanged.
- R4: The hardware lock is active when guard_en is 1 and `wp_n` is 0. A status write that meets an active lock at its strobe is refused with `sr_reject`, and nothing changes.
- R5: While guard_en is 0, `wp_n` has no effect. A status write with the latch set commits on the first clock edge with `cs_n` high. That edge loads bits 7:2 from `sr_guard_in`/`sr_prot_in` and pulses `sr_accept`.
- R6: If the lock becomes active while a status write is pending (cs_n still low), the write is cancelled: `sr_reject` pulses, bits 7:2 keep their old value, and busy does not rise.
- R7: Once a status write has committed, a later low on `wp_n` leaves the new register value untouched.
- R8: `busy` is high for exactly `BUSY_CYCLES` cycles after each accepted operation. The write latch reads 0 once busy falls.
- R9: The protected sectors depend on prot_sel, with the sector being addr[17:16]. 00 protects no sector, 01 protects sector 3, 10 protects sectors 2 and 3, and 11 protects all four sectors.
- R10: A program or erase pulses `op_grant` and starts busy only when the latch is set and the sector is not protected. Otherwise it pulses `op_deny`.
- R11: While busy, every command strobe is ignored: no pulse appears and the latch does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip-select level, low while a command is in progress |
| wp_n | input | 1 | Write-protect pin level, active low |
| cmd_set_latch | input | 1 | Write-enable command strobe |
| cmd_clr_latch | input | 1 | Write-disable command strobe |
| cmd_sr_write | input | 1 | Status-register write command strobe |
| cmd_prog | input | 1 | Program command strobe |
| cmd_erase | input | 1 | Sector erase command strobe |
| addr | input | ADDR_W | Target byte address |
| sr_guard_in | input | 1 | New guard-enable value for a status write |
| sr_prot_in | input | 2 | New protect selector for a status write |
| status_o | output | 8 | Status register value |
| busy | output | 1 | Internal write cycle in progress |
| op_grant | output | 1 | One-cycle pulse: program or erase accepted |
| op_deny | output | 1 | One-cycle pulse: program or erase refused |
| sr_accept | output | 1 | One-cycle pulse: status write committed |
| sr_reject | output | 1 | One-cycle pulse: status write refused or cancelled |

## Verification
The assertions assume the command strobes last one cycle and arrive only on clock edges. They also assume `sr_guard_in` and `sr_prot_in` are stable only on the cycle of the status write strobe. The bench drives every input on the falling clock edge and raises each strobe for exactly one cycle. It keeps `cs_n` low from a status write strobe until the commit or abort is meant to happen. It starts a new operation only after busy has fallen, except in the tests that deliberately send strobes into the busy window.

// File: rtl/sr_guard.sv
module sr_guard #(
  parameter int ADDR_W      = 18,
  parameter int SECT_W      = 2,
  parameter int BUSY_CYCLES = 4,
  localparam int CNT_W      = $clog2(BUSY_CYCLES + 1),
  localparam int NSECT      = 1 << SECT_W,
  localparam int HALF_SECT  = NSECT / 2,
  localparam int QTR3_SECT  = (NSECT * 3) / 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              wp_n,
  input  logic              cmd_set_latch,
  input  logic              cmd_clr_latch,
  input  logic              cmd_sr_write,
  input  logic              cmd_prog,
  input  logic              cmd_erase,
  input  logic [ADDR_W-1:0] addr,
  input  logic              sr_guard_in,
  input  logic [1:0]        sr_prot_in,
  output logic [7:0]        status_o,
  output logic              busy,
  output logic              op_grant,
  output logic              op_deny,
  output logic              sr_accept,
  output logic              sr_reject
);

  logic             wr_latch, guard_en, pend, pend_guard;
  logic [1:0]       prot_sel, pend_prot;
  logic [CNT_W-1:0] cnt;
  logic             prot_hit;

  wire [SECT_W-1:0] sector     = addr[ADDR_W-1 -: SECT_W];
  wire              unused_low = ^addr[ADDR_W-SECT_W-1:0];
  wire              hw_lock    = guard_en & ~wp_n;
  wire              array_cmd  = cmd_prog | cmd_erase;

  always_comb begin
    unique case (prot_sel)
      2'b00:   prot_hit = 1'b0;
      2'b01:   prot_hit = (int'(sector) >= QTR3_SECT);
      2'b10:   prot_hit = (int'(sector) >= HALF_SECT);
      default: prot_hit = 1'b1;
    endcase
  end

  assign status_o = {guard_en, 3'b000, prot_sel, wr_latch, busy};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_latch   <= 1'b0;
      guard_en   <= 1'b0;
      prot_sel   <= 2'b00;
      pend       <= 1'b0;
      pend_guard <= 1'b0;
      pend_prot  <= 2'b00;
      busy       <= 1'b0;
      cnt        <= '0;
      op_grant   <= 1'b0;
      op_deny    <= 1'b0;
      sr_accept  <= 1'b0;
      sr_reject  <= 1'b0;
    end else begin
      op_grant  <= 1'b0;
      op_deny   <= 1'b0;
      sr_accept <= 1'b0;
      sr_reject <= 1'b0;
      if (busy) begin
        if (cnt == CNT_W'(1)) begin
          busy     <= 1'b0;
          wr_latch <= 1'b0;
        end else begin
          cnt <= cnt - CNT_W'(1);
        end
      end else if (pend) begin
        if (hw_lock) begin
          pend      <= 1'b0;
          sr_reject <= 1'b1;
        end else if (cs_n) begin
          pend      <= 1'b0;
          guard_en  <= pend_guard;
          prot_sel  <= pend_prot;
          busy      <= 1'b1;
          cnt       <= CNT_W'(BUSY_CYCLES);
          sr_accept <= 1'b1;
        end
      end else if (cmd_sr_write) begin
        if (wr_latch && !hw_lock) begin
          pend       <= 1'b1;
          pend_guard <= sr_guard_in;
          pend_prot  <= sr_prot_in;
        end else begin
          sr_reject <= 1'b1;
        end
      end else if (array_cmd) begin
        if (wr_latch && !prot_hit) begin
          op_grant <= 1'b1;
          busy     <= 1'b1;
          cnt      <= CNT_W'(BUSY_CYCLES);
        end else begin
          op_deny <= 1'b1;
        end
      end else if (cmd_set_latch) begin
        wr_latch <= 1'b1;
      end else if (cmd_clr_latch) begin
        wr_latch <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/sr_guard_chk.sv
module sr_guard_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       wp_n,
  input logic [7:0] status_o,
  input logic       busy,
  input logic       op_grant,
  input logic       op_deny,
  input logic       sr_accept,
  input logic       sr_reject
);

  p_grant_deny_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(op_grant && op_deny));

  p_grant_needs_latch_r10: assert property (@(posedge clk) disable iff (!rst_n)
    op_grant |-> $past(status_o[1]));

  p_busy_entry_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> (op_grant || sr_accept));

  p_latch_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> !status_o[1]);

  p_frozen_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(status_o[7:2]));

  p_reject_keeps_r3: assert property (@(posedge clk) disable iff (!rst_n)
    sr_reject |-> ($stable(status_o[7:2]) && !busy));

  p_commit_unlocked_r4: assert property (@(posedge clk) disable iff (!rst_n)
    sr_accept |-> !($past(status_o[7]) && !$past(wp_n)));

  p_one_result_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(sr_accept && sr_reject));

endmodule

bind sr_guard sr_guard_chk u_chk (.*);

// File: tb/sr_guard_tb.sv
module sr_guard_tb;
  localparam int CLK_PERIOD = 10;
  localparam int BUSY_N     = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs_n = 1'b1, wp_n = 1'b1;
  logic cmd_set_latch = 0, cmd_clr_latch = 0, cmd_sr_write = 0, cmd_prog = 0, cmd_erase = 0;
  logic [17:0] addr = '0;
  logic sr_guard_in = 0;
  logic [1:0] sr_prot_in = 0;
  logic [7:0] status_o;
  logic busy, op_grant, op_deny, sr_accept, sr_reject;

  int checks = 0, errors = 0;
  bit done = 0;

  sr_guard #(.BUSY_CYCLES(BUSY_N)) u_dut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  // {guard_en, wp_n, latch set, expect commit}
  localparam logic [3:0] VEC [8] = '{4'b0000, 4'b0011, 4'b0100, 4'b0111,
                                      4'b1000, 4'b1010, 4'b1100, 4'b1111};

  task automatic tick(); @(negedge clk); endtask

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic strobe(int k);
    case (k)
      0: cmd_set_latch = 1; 1: cmd_clr_latch = 1; 2: cmd_sr_write = 1;
      3: cmd_prog = 1;      default: cmd_erase = 1;
    endcase
    tick();
    cmd_set_latch = 0; cmd_clr_latch = 0; cmd_sr_write = 0; cmd_prog = 0; cmd_erase = 0;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 50 && busy; i++) tick();
  endtask

  task automatic do_reset();
    rst_n = 0; cs_n = 1; wp_n = 1;
    tick(); tick();
    rst_n = 1;
    tick();
  endtask

  task automatic set_sr(logic g, logic [1:0] p);
    wp_n = 1; cs_n = 0;
    strobe(0);
    sr_guard_in = g; sr_prot_in = p;
    strobe(2);
    cs_n = 1;
    tick();
    wait_idle();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int n;
    logic exp;
    do_reset();
    // R1 reset state
    check("R1 status", status_o, 8'h00);
    check("R1 pulses", {busy, op_grant, op_deny, sr_accept, sr_reject}, 5'b0);

    // R2 latch set and clear
    strobe(0);
    check("R2 latch set", status_o, 8'h02);
    strobe(1);
    check("R2 latch clear", status_o, 8'h00);

    // Table walk: R3 R4 R5 over guard_en x wp_n x latch
    for (int v = 0; v < 8; v++) begin
      do_reset();
      if (VEC[v][3]) set_sr(1'b1, 2'b00);
      if (VEC[v][1]) strobe(0);
      wp_n = VEC[v][2]; cs_n = 0;
      sr_guard_in = VEC[v][3]; sr_prot_in = 2'b01;
      strobe(2);
      check($sformatf("R3/R4 reject vec%0d", v), sr_reject, !VEC[v][0]);
      cs_n = 1;
      tick();
      check($sformatf("R5 accept vec%0d", v), sr_accept, VEC[v][0]);
      check($sformatf("R5 prot vec%0d", v), status_o[3:2], VEC[v][0] ? 2'b01 : 2'b00);
      wait_idle();
      wp_n = 1;
    end

    // R6 lock engages while pending, cs_n still low
    do_reset();
    set_sr(1'b1, 2'b00);
    strobe(0);
    cs_n = 0; sr_guard_in = 1; sr_prot_in = 2'b11;
    strobe(2);
    check("R6 no early reject", sr_reject, 1'b0);
    wp_n = 0;
    tick();
    check("R6 abort pulse", sr_reject, 1'b1);
    cs_n = 1;
    tick();
    check("R6 unchanged", {status_o[7:2], busy, sr_accept}, {6'b100000, 2'b00});
    wp_n = 1;

    // R7 lock after commit; R8 busy length and latch clear
    strobe(0);
    cs_n = 0; sr_guard_in = 1; sr_prot_in = 2'b10;
    strobe(2);
    cs_n = 1;
    tick();
    check("R7 commit", {sr_accept, busy}, 2'b11);
    wp_n = 0;
    n = 0;
    while (busy && n < 50) begin n++; tick(); end
    check("R7 value kept", status_o[7:2], 6'b100010);
    check("R8 busy length", n, BUSY_N);
    check("R8 latch cleared", status_o[1], 1'b0);
    wp_n = 1;

    // R9 R10 protection map
    for (int p = 0; p < 4; p++) begin
      do_reset();
      set_sr(1'b0, 2'(p));
      for (int s = 0; s < 4; s++) begin
        exp = (p == 3) || (p == 1 && s == 3) || (p == 2 && s >= 2) ? 1'b0 : 1'b1;
        strobe(0);
        addr = {2'(s), 16'h1234};
        strobe((s % 2 == 0) ? 3 : 4);
        check($sformatf("R9 grant p%0d s%0d", p, s), {op_grant, op_deny}, {exp, !exp});
        wait_idle();
      end
    end

    // R10 no latch
    do_reset();
    addr = 18'h00010;
    strobe(3);
    check("R10 deny without latch", {op_grant, op_deny, busy}, 3'b010);

    // R11 strobes during busy ignored
    strobe(0);
    strobe(4);
    check("R11 erase started", busy, 1'b1);
    strobe(1);
    check("R11 clr ignored", status_o[1], 1'b1);
    strobe(3);
    check("R11 prog ignored", {op_grant, op_deny}, 2'b00);
    wait_idle();
    check("R11 idle latch", status_o[1], 1'b0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule